// File: doc/BRIEF.md
# Numerically Controlled Oscillator Core with Coarse Phase Offset

This core is a cosine synthesizer for a sampled-data output path. On every system clock, while it runs, it adds a 32-bit tuning word to a 32-bit phase register. The register wraps modulo 2^32, so the output frequency is tuning_word × f_clk / 2^32 and the waveform stays phase-continuous across frequency changes.

The upper 14 bits of the phase register are kept. A 5-bit coarse offset is added into bits [13:9] of that 14-bit phase. One offset step is 1/32 of a cycle, or 11.25°. The resulting phase is mapped to a 10-bit offset-binary cosine sample for a downstream converter.

The control side loads a tuning word, an offset and a power-down flag on one strobe. A new tuning word reaches the output 18 clocks after the strobe. A new offset reaches it 13 clocks after the strobe.

Top module: `nco_core`

## Requirements
- R1: While `rst` is sampled high and on the edge that samples it, `amp` is 1023 (full scale, cosine of 0°) and `amp_vld` is 0. Reset clears the phase register, the active tuning word and the active offset, so after release `amp` stays at 1023 until an update lands.
- R2: Each edge with `amp_vld` high advances the phase P by the active tuning word modulo 2^32. `amp` is then within 1.5 codes of 511.5 + 511.5·cos(2π·p/16384), where p = (P[31:18] + 512·offset) mod 16384. The output is exactly 1023 at p = 0 and exactly 0 at p = 8192.
- R3: The 5-bit offset adds offset × 512 to the 14-bit phase modulo 16384, so each offset code is 11.25°. All 32 codes apply.
- R4: A tuning word taken by a strobe on edge u is first used for the phase step of the sample produced on edge u+18.
- R5: An offset taken by a strobe on edge u first shapes the sample produced on edge u+13.
- R6: `ftw`, `pofs` and `pdn` are sampled only on edges where `upd` is high. Changes to them without a strobe have no effect on `amp` or `amp_vld`.
- R7: If the flag taken by a strobe on edge u is set, `amp` holds its value and `amp_vld` is 0 from edge u+1 on. A later strobe with the flag clear resumes the output from the held phase, with no lost or extra phase step.
- R8: `amp_vld` is 1 on every edge that is not a reset edge and that follows a cycle in which power-down is not active.
- R9: A strobe sampled on or before a reset edge never lands. Its tuning word and offset are discarded.
- R10: Strobes on consecutive or closely spaced edges each land at their own latency, in order. An offset from one strobe can land on the same edge as the tuning word from an earlier strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| upd | input | 1 | Update strobe: loads `ftw`, `pofs` and `pdn` on this edge |
| ftw | input | 32 | Frequency tuning word |
| pofs | input | 5 | Coarse phase offset, 11.25° per code |
| pdn | input | 1 | Power-down flag, 1 = stop sample clocking |
| amp | output | 10 | Offset-binary cosine sample, 1023 = positive peak, 512 = mid-scale |
| amp_vld | output | 1 | High when `amp` was refreshed on this edge |

## Verification
Because the two latencies differ, two functions can act on the same output sample. The offset of one strobe and the tuning word of an earlier strobe land on one edge when the strobes are five cycles apart. The bench provokes this, and also strobes on back-to-back edges, and it strobes on the very edge that reset is sampled. A reference in the bench keeps the strobe history per edge and the phase arithmetically. On every edge it predicts which tuning word and which offset are active, so a landing one cycle early or late, or a strobe that survives reset, shows up as an amplitude error at that edge.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Magnitude of one quarter-wave entry. Entries are sampled half a step
  // off the grid so that the quadrant mirror is exact: entry i stands for
  // the angle (i + 0.5) / n_ent of a quarter turn.
  function automatic int qw_mag(int idx, int n_ent, int amp_w);
    real half_span;
    real ang;
    half_span = real'(2 ** (amp_w - 1)) - 0.5;
    ang = 1.5707963267948966 * (real'(idx) + 0.5) / real'(n_ent);
    return $rtoi(half_span * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/nco_ctrl_dly.sv
module nco_ctrl_dly #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);

  generate
    if (DEPTH == 0) begin : g_thru
      assign out_vld = in_vld;
      assign out_dat = in_dat;
    end else begin : g_pipe
      logic [DEPTH-1:0] v_q;
      logic [W-1:0]     d_q [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) begin
            v_q[i] <= 1'b0;
            d_q[i] <= '0;
          end
        end else begin
          v_q[0] <= in_vld;
          d_q[0] <= in_dat;
          for (int i = 1; i < DEPTH; i++) begin
            v_q[i] <= v_q[i-1];
            d_q[i] <= d_q[i-1];
          end
        end
      end

      assign out_vld = v_q[DEPTH-1];
      assign out_dat = d_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 14,
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] ftw,
  input  logic [OFS_W-1:0] pofs,
  output logic [PH_W-1:0]  ph
);

  localparam int OFS_SH = PH_W - OFS_W;

  function automatic logic [PH_W-1:0] join_phase(logic [ACC_W-1:0] acc_v,
                                                 logic [OFS_W-1:0] ofs_v);
    return acc_v[ACC_W-1 -: PH_W] + {ofs_v, {OFS_SH{1'b0}}};
  endfunction

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ph    <= '0;
    end else if (en) begin
      acc_q <= acc_q + ftw;
      ph    <= join_phase(acc_q, pofs);
    end
  end

endmodule

// File: rtl/nco_cos_rom.sv
module nco_cos_rom
  import nco_pkg::*;
#(
  parameter int PH_W   = 14,
  parameter int AMP_W  = 10,
  parameter int LUT_AW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PH_W-1:0]  ph,
  output logic [AMP_W-1:0] amp
);

  localparam int NENT  = 2 ** LUT_AW;
  localparam int MAG_W = AMP_W - 1;
  localparam int DROP  = PH_W - 2 - LUT_AW;
  localparam logic [PH_W-1:0]  QTR  = PH_W'(1) << (PH_W - 2);
  localparam logic [AMP_W-1:0] HALF = AMP_W'(1) << (AMP_W - 1);

  logic [MAG_W-1:0] tbl [NENT];

  generate
    for (genvar g = 0; g < NENT; g++) begin : g_ent
      localparam int MAG = qw_mag(g, NENT, AMP_W);
      assign tbl[g] = MAG_W'(MAG);
    end
  endgenerate

  logic [PH_W-1:0]   rot;
  logic [1:0]        quad;
  logic [PH_W-3:0]   frac;
  logic [LUT_AW-1:0] fidx;
  logic [LUT_AW-1:0] idx;
  logic [MAG_W-1:0]  mag;
  logic [AMP_W-1:0]  amp_nxt;

  // cos(x) = sin(x + quarter turn): rotate, then fold into the first quadrant
  assign rot  = ph + QTR;
  assign quad = rot[PH_W-1 -: 2];
  assign frac = rot[PH_W-3:0];
  assign fidx = LUT_AW'(frac >> DROP);
  assign idx  = quad[0] ? ~fidx : fidx;
  assign mag  = tbl[idx];

  always_comb begin
    if (quad[1]) amp_nxt = (HALF - AMP_W'(1)) - {1'b0, mag};
    else         amp_nxt = HALF + {1'b0, mag};
  end

  always_ff @(posedge clk) begin
    if (rst)     amp <= '1;
    else if (en) amp <= amp_nxt;
  end

endmodule

// File: rtl/nco_core.sv
module nco_core #(
  parameter int ACC_W     = 32,
  parameter int OFS_W     = 5,
  parameter int PH_W      = 14,
  parameter int AMP_W     = 10,
  parameter int LUT_AW    = 10,
  parameter int FREQ_LAT  = 18,
  parameter int PHASE_LAT = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [ACC_W-1:0] ftw,
  input  logic [OFS_W-1:0] pofs,
  input  logic             pdn,
  output logic [AMP_W-1:0] amp,
  output logic             amp_vld
);

  // Registers on the sample path after the active-word register:
  // tuning word -> phase register -> phase stage -> amplitude register.
  localparam int FDLY = FREQ_LAT - 3;
  // Offset -> phase stage -> amplitude register.
  localparam int PDLY = PHASE_LAT - 2;

  logic             f_land;
  logic             p_land;
  logic [ACC_W-1:0] f_dat;
  logic [OFS_W-1:0] p_dat;
  logic [ACC_W-1:0] ftw_act;
  logic [OFS_W-1:0] pofs_act;
  logic             pdn_act;
  logic             run_en;
  logic [PH_W-1:0]  ph;

  nco_ctrl_dly #(.W(ACC_W), .DEPTH(FDLY)) u_fdly (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (upd),
    .in_dat  (ftw),
    .out_vld (f_land),
    .out_dat (f_dat)
  );

  nco_ctrl_dly #(.W(OFS_W), .DEPTH(PDLY)) u_pdly (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (upd),
    .in_dat  (pofs),
    .out_vld (p_land),
    .out_dat (p_dat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_act  <= '0;
      pofs_act <= '0;
      pdn_act  <= 1'b0;
    end else begin
      if (f_land) ftw_act  <= f_dat;
      if (p_land) pofs_act <= p_dat;
      if (upd)    pdn_act  <= pdn;
    end
  end

  assign run_en = ~pdn_act;

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W), .OFS_W(OFS_W)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .en   (run_en),
    .ftw  (ftw_act),
    .pofs (pofs_act),
    .ph   (ph)
  );

  nco_cos_rom #(.PH_W(PH_W), .AMP_W(AMP_W), .LUT_AW(LUT_AW)) u_rom (
    .clk (clk),
    .rst (rst),
    .en  (run_en),
    .ph  (ph),
    .amp (amp)
  );

  always_ff @(posedge clk) begin
    if (rst) amp_vld <= 1'b0;
    else     amp_vld <= run_en;
  end

endmodule

// File: rtl/nco_core_chk.sv
module nco_core_chk #(
  parameter int AMP_W     = 10,
  parameter int FREQ_LAT  = 18,
  parameter int PHASE_LAT = 13
) (
  input logic             clk,
  input logic             rst,
  input logic [AMP_W-1:0] amp,
  input logic             amp_vld,
  input logic             pdn_act,
  input logic             f_land,
  input logic             p_land
);

  localparam int GAP = FREQ_LAT - PHASE_LAT;
  localparam int CW  = $clog2(GAP + 2);

  // Updates whose offset has landed but whose tuning word has not yet.
  logic [CW-1:0] outst;

  always_ff @(posedge clk) begin
    if (rst)                    outst <= '0;
    else if (p_land && !f_land) outst <= outst + CW'(1);
    else if (!p_land && f_land) outst <= outst - CW'(1);
  end

  AST_RESET_FULLSCALE: assert property (@(posedge clk)
    rst |=> (amp == {AMP_W{1'b1}} && !amp_vld)); // R1

  AST_PDN_FREEZE: assert property (@(posedge clk) disable iff (rst)
    pdn_act |=> ($stable(amp) && !amp_vld)); // R7

  AST_RUN_VALID: assert property (@(posedge clk) disable iff (rst)
    !pdn_act |=> amp_vld); // R8

  AST_LAND_ORDER: assert property (@(posedge clk) disable iff (rst)
    f_land |-> (outst != '0)); // R4

  AST_LAND_BOUND: assert property (@(posedge clk) disable iff (rst)
    outst <= CW'(GAP)); // R5

endmodule

bind nco_core nco_core_chk #(
  .AMP_W     (AMP_W),
  .FREQ_LAT  (FREQ_LAT),
  .PHASE_LAT (PHASE_LAT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .amp     (amp),
  .amp_vld (amp_vld),
  .pdn_act (pdn_act),
  .f_land  (f_land),
  .p_land  (p_land)
);

// File: tb/sim_nco_core.sv
`timescale 1ns/1ps
module sim_nco_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd = 1'b0;
  logic        pdn = 1'b0;
  logic [31:0] ftw = '0;
  logic [4:0]  pofs = '0;
  wire  [9:0]  amp;
  wire         amp_vld;

  always #2 clk = ~clk;

  nco_core u0 (
    .clk(clk), .rst(rst), .upd(upd), .ftw(ftw), .pofs(pofs), .pdn(pdn),
    .amp(amp), .amp_vld(amp_vld)
  );

  localparam int HN    = 4096;
  localparam int F_LAT = 18;
  localparam int P_LAT = 13;

  int    n_vec = 0;
  int    n_bad = 0;
  int    k = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  bit          h_rst [HN];
  bit          h_upd [HN];
  bit          h_pdn [HN];
  logic [31:0] h_ftw [HN];
  logic [4:0]  h_ofs [HN];

  logic [31:0] m_p = '0;
  logic [31:0] m_f = '0;
  int          m_o = 0;
  bit          m_pdn = 1'b0;
  int          m_lastr = 0;
  int          last_amp = 1023;

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic fail(real expv, bit ev);
    n_bad++;
    $display("FAIL %s edge %0d: amp=%0d vld=%0d, expected amp=%0.2f vld=%0d",
             cur_req, k, amp, amp_vld, expv, ev);
  endtask

  task automatic model_check();
    bit  ev;
    int  ph;
    real ideal;
    n_vec++;
    if (h_rst[k]) begin
      m_p = '0; m_f = '0; m_o = 0; m_pdn = 1'b0; m_lastr = k;
      if (amp !== 10'd1023 || amp_vld !== 1'b0) fail(1023.0, 1'b0);
    end else begin
      ev = !m_pdn;
      if (k >= F_LAT && k - F_LAT > m_lastr && h_upd[k-F_LAT]) m_f = h_ftw[k-F_LAT];
      if (k >= P_LAT && k - P_LAT > m_lastr && h_upd[k-P_LAT]) m_o = int'(h_ofs[k-P_LAT]);
      if (ev) begin
        m_p = m_p + m_f;
        ph = (int'(m_p >> 18) + m_o * 512) % 16384;
        ideal = 511.5 + 511.5 * $cos(2.0 * 3.141592653589793 * real'(ph) / 16384.0);
        if ($isunknown({amp, amp_vld}) || amp_vld !== 1'b1)
          fail(ideal, ev);
        else if ((real'(amp) - ideal) > 1.5 || (ideal - real'(amp)) > 1.5)
          fail(ideal, ev);
        else if ((ph == 0 && amp != 10'd1023) || (ph == 8192 && amp != 10'd0))
          fail(ideal, ev);
      end else begin
        if ($isunknown({amp, amp_vld}) || amp_vld !== 1'b0 || int'(amp) != last_amp)
          fail(real'(last_amp), ev);
      end
      if (h_upd[k]) m_pdn = h_pdn[k];
    end
    if (!$isunknown(amp)) last_amp = int'(amp);
  endtask

  task automatic tick();
    @(posedge clk);
    k++;
    if (k < HN) begin
      h_rst[k] = rst; h_upd[k] = upd; h_pdn[k] = pdn;
      h_ftw[k] = ftw; h_ofs[k] = pofs;
    end
    @(negedge clk);
    if (k < HN) model_check();
  endtask

  task automatic run(int n);
    repeat (n) tick();
  endtask

  task automatic strobe(logic [31:0] f, logic [4:0] o, bit p);
    ftw = f; pofs = o; pdn = p; upd = 1'b1;
    tick();
    upd = 1'b0;
  endtask

  logic [31:0] words [16] = '{
    32'h8000_0000, 32'hFFFF_FFFF, 32'h4000_0000, 32'h0000_4000,
    32'h0123_4567, 32'h7FFF_FFFF, 32'hC000_0000, 32'h0040_0000,
    32'h1555_5555, 32'h2AAA_AAAA, 32'hFF00_0000, 32'h0000_0001,
    32'h3210_FEDC, 32'h9E37_79B9, 32'h0800_0000, 32'h6000_0001
  };

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    report();
  end

  initial begin
    // R1: reset state and idle full scale after release
    cur_req = "R1";
    rst = 1'b1;
    run(6);
    rst = 1'b0;
    run(25);

    // R6: inputs change without a strobe: no effect
    cur_req = "R6";
    ftw = 32'h1234_5678; pofs = 5'd17; pdn = 1'b1;
    run(30);
    pdn = 1'b0;

    // R4: frequency landing edge, then R2 steady accumulation, R8 valid
    cur_req = "R4";
    strobe(32'h0123_4567, 5'd0, 1'b0);
    run(30);
    cur_req = "R2";
    run(150);
    cur_req = "R8";
    run(100);

    // R5 / R3: offset landing edge with large offset steps
    cur_req = "R5";
    strobe(32'h0123_4567, 5'd7, 1'b0);
    run(40);
    strobe(32'h0123_4567, 5'd31, 1'b0);
    run(40);

    // R10: offset of second strobe lands on the same edge as the word of the first
    cur_req = "R10";
    strobe(32'h0800_0000, 5'd3, 1'b0);
    run(4);
    strobe(32'h2000_0000, 5'd20, 1'b0);
    run(10);
    strobe(32'h0040_0000, 5'd1, 1'b0);
    strobe(32'h3000_0000, 5'd9, 1'b0);
    strobe(32'h0000_8000, 5'd0, 1'b0);
    run(40);

    // R2: sweep of tuning words including half rate, minus one and wrap cases
    cur_req = "R2";
    for (int i = 0; i < 16; i++) begin
      strobe(words[i], 5'(i), 1'b0);
      run(63);
    end

    // R3: every offset code on a stopped phase
    cur_req = "R3";
    for (int o = 0; o < 32; o++) begin
      strobe(32'h0, 5'(o), 1'b0);
      run(15);
    end

    // R7: power-down holds output, resume is phase continuous
    cur_req = "R7";
    strobe(32'h0123_4567, 5'd5, 1'b0);
    run(25);
    strobe(32'h0123_4567, 5'd5, 1'b1);
    run(24);
    strobe(32'h0123_4567, 5'd5, 1'b0);
    run(40);

    // R9: pending strobes and a strobe on the reset edge are discarded
    cur_req = "R9";
    strobe(32'h2000_0000, 5'd9, 1'b0);
    run(3);
    rst = 1'b1;
    run(4);
    ftw = 32'h4000_0000; pofs = 5'd12; upd = 1'b1;
    tick();
    upd = 1'b0;
    rst = 1'b0;
    run(40);

    // R2: operation after reset
    cur_req = "R2";
    strobe(32'h0800_0000, 5'd4, 1'b0);
    run(60);

    report();
  end

endmodule